// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block is the addressing layer of a single-wire bus slave. It sits between a link layer, which turns bus timing into per-bit strobes and detects the bus reset and presence handshake, and a memory command layer. After every line reset it collects one 8-bit ROM command from the master, least significant bit first. It then runs one of four exchanges against a 64-bit identity: send the identity (read), compare an identity sent by the master (match), take part in the bit-wise elimination search (search), or skip addressing entirely (skip).

The identity is a family code in the low byte, a 48-bit serial number above it, and a check byte in the top byte. The family code and serial number are module parameters. The check byte is not stored: it is computed at elaboration from the lower 56 bits. When an exchange completes successfully, the block raises `mem_en` to hand the bus to the memory layer. When an exchange fails, or the command code is unknown, the block stays silent until the next line reset.

Top module: `rom_cmd_engine`

## Requirements
- R1: After a line reset the block collects exactly 8 written bits as the command, the first written bit being bit 0. The codes are 33h read, 55h match, F0h search and CCh skip. Read strobes that arrive while the command is being collected are ignored.
- R2: After a read command the block drives 64 read slots with identity bits 0 to 63 in order: family code, then serial number, then check byte. It raises `mem_en` after the 64th slot.
- R3: The check byte (identity bits 63:56) is the CRC with polynomial x^8+x^5+x^4+1 and a zero start value, fed from identity bit 0 upward over bits 0 to 55. Feeding all 64 identity bits through the same generator leaves zero.
- R4: After a match command the block compares 64 written bits with identity bits 0 to 63 and raises `mem_en` only if all of them are equal. On the first unequal bit it goes silent: `tx_en` and `mem_en` stay 0 until a line reset, whatever bits follow.
- R5: After a search command, for each identity bit i from 0 to 63 the block drives bit i in one read slot, then its complement in the next read slot, then takes a written bit. A written bit equal to bit i moves on to bit i+1, or raises `mem_en` after bit 63. An unequal written bit makes the block silent until a line reset.
- R6: A skip command raises `mem_en` in the cycle after the 8th command bit, with no identity exchange.
- R7: Any command code other than the four listed makes the block silent: no drive, no `mem_en`, until a line reset.
- R8: A line reset in any state returns the block to command collection and clears `mem_en` in the next cycle.
- R9: `tx_en` is 1 only in read and search bit or complement slots. While `mem_en` is 1, or while the block is silent, `tx_en` is 0.
- R10: After the asynchronous reset, `mem_en` and `tx_en` are 0 and the block waits for a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rst | input | 1 | One-cycle pulse: link layer finished a bus reset/presence |
| wr_stb | input | 1 | One-cycle pulse: master wrote a bit |
| wr_bit | input | 1 | Value of the written bit, valid with `wr_stb` |
| rd_stb | input | 1 | One-cycle pulse: the current read slot ends, advance |
| tx_en | output | 1 | Block owns the current read slot |
| tx_bit | output | 1 | Bit to present in the current read slot, valid with `tx_en` |
| mem_en | output | 1 | Addressing done; memory layer may take the bus |

## Verification
The assertions assume that the link layer gives single-cycle strobes and never raises `wr_stb` and `rd_stb` in the same cycle, since one bus slot is either a write or a read. They also assume that `line_rst` has priority over any strobe that arrives with it. The stimulus sends each strobe alone for one cycle, with an idle cycle between strobes, and raises `line_rst` only between bit exchanges. Under these conditions the search check of a complement against the bit before it and the checks of silence and grant hold for every path.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;
  localparam int CMD_BITS = 8;
  localparam int FAM_BITS = 8;
  localparam int SER_BITS = 48;
  localparam int CRC_BITS = 8;

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_SKIP   = 8'hCC;

  // reflected form of x^8 + x^5 + x^4 + 1
  localparam logic [7:0] CRC_TAPS = 8'h8C;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SBIT,
    ST_SCMP,
    ST_SDIR,
    ST_GRANT,
    ST_DEAD
  } eng_state_t;
endpackage

// File: rtl/rce_id_gen.sv
module rce_id_gen import rom_cmd_pkg::*; #(
  parameter logic [FAM_BITS-1:0] FAMILY_CODE = 8'h08,
  parameter logic [SER_BITS-1:0] SERIAL_NO   = 48'h00A3_5C71_E904
) (
  output logic [FAM_BITS+SER_BITS+CRC_BITS-1:0] id_o
);
  localparam int BODY_BITS = FAM_BITS + SER_BITS;

  logic [BODY_BITS-1:0]           body;
  logic [BODY_BITS:0][CRC_BITS-1:0] stage;

  assign body     = {SERIAL_NO, FAMILY_CODE};
  assign stage[0] = '0;

  // one shift-and-xor stage per body bit, lowest bit first
  for (genvar g = 0; g < BODY_BITS; g++) begin : g_crc
    logic fb;
    assign fb           = stage[g][0] ^ body[g];
    assign stage[g + 1] = (stage[g] >> 1) ^ (fb ? CRC_TAPS : '0);
  end

  assign id_o = {stage[BODY_BITS], body};
endmodule

// File: rtl/rce_bitcnt.sv
module rce_bitcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)      q_n = '0;
    else if (inc) q_n = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr || inc) q <= q_n;
  end
endmodule

// File: rtl/rce_cmd_sr.sv
module rce_cmd_sr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  // first bit received ends up in bit 0 after W shifts
  always_comb begin
    q_n = q;
    if (clr)           q_n = '0;
    else if (shift_en) q_n = {bit_i, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= '0;
    else if (clr || shift_en) q <= q_n;
  end
endmodule

// File: rtl/rom_cmd_engine.sv
module rom_cmd_engine import rom_cmd_pkg::*; #(
  parameter logic [7:0]  FAMILY_CODE = 8'h08,
  parameter logic [47:0] SERIAL_NO   = 48'h00A3_5C71_E904
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_rst,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic rd_stb,
  output logic tx_en,
  output logic tx_bit,
  output logic mem_en
);
  localparam int ID_BITS = FAM_BITS + SER_BITS + CRC_BITS;
  localparam int CNT_W   = $clog2(ID_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ID_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);

  eng_state_t           st, st_n;
  logic [ID_BITS-1:0]   id;
  logic [CNT_W-1:0]     cnt;
  logic [CMD_BITS-1:0]  cmd_q, cmd_full;
  logic                 cnt_clr, cnt_inc, cmd_shift;
  logic                 id_bit, last;

  rce_id_gen #(.FAMILY_CODE(FAMILY_CODE), .SERIAL_NO(SERIAL_NO)) u_id (
    .id_o(id)
  );

  rce_bitcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .q(cnt)
  );

  assign cmd_shift = (st == ST_CMD) && wr_stb && !line_rst;

  rce_cmd_sr #(.W(CMD_BITS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(line_rst), .shift_en(cmd_shift),
    .bit_i(wr_bit), .q(cmd_q)
  );

  assign cmd_full = {wr_bit, cmd_q[CMD_BITS-1:1]};
  assign id_bit   = id[cnt];
  assign last     = (cnt == CNT_LAST);

  always_comb begin
    st_n    = st;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (line_rst) begin
      st_n    = ST_CMD;
      cnt_clr = 1'b1;
    end else begin
      unique case (st)
        ST_CMD: if (wr_stb) begin
          if (cnt == CMD_LAST) begin
            cnt_clr = 1'b1;
            case (cmd_full)
              OP_READ:   st_n = ST_READ;
              OP_MATCH:  st_n = ST_MATCH;
              OP_SEARCH: st_n = ST_SBIT;
              OP_SKIP:   st_n = ST_GRANT;
              default:   st_n = ST_DEAD;
            endcase
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_READ: if (rd_stb) begin
          if (last) st_n = ST_GRANT;
          else      cnt_inc = 1'b1;
        end
        ST_MATCH: if (wr_stb) begin
          if (wr_bit != id_bit) st_n = ST_DEAD;
          else if (last)        st_n = ST_GRANT;
          else                  cnt_inc = 1'b1;
        end
        ST_SBIT: if (rd_stb) st_n = ST_SCMP;
        ST_SCMP: if (rd_stb) st_n = ST_SDIR;
        ST_SDIR: if (wr_stb) begin
          if (wr_bit != id_bit) st_n = ST_DEAD;
          else if (last)        st_n = ST_GRANT;
          else begin
            cnt_inc = 1'b1;
            st_n    = ST_SBIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_CMD;
    else        st <= st_n;
  end

  assign tx_en  = (st == ST_READ) || (st == ST_SBIT) || (st == ST_SCMP);
  assign tx_bit = (st == ST_SCMP) ? ~id_bit : id_bit;
  assign mem_en = (st == ST_GRANT);

  AST_LINE_RST_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |=> !mem_en); // R8

  AST_SILENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEAD && !line_rst) |=> (!tx_en && !mem_en)); // R4

  AST_SEARCH_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SBIT && rd_stb && !line_rst) |=> (tx_en && tx_bit == !$past(tx_bit))); // R5

  AST_SKIP_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && wr_stb && !line_rst && cnt == CMD_LAST && cmd_full == OP_SKIP)
    |=> mem_en); // R6

  AST_READ_END_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && rd_stb && !line_rst && last) |=> mem_en); // R2

  AST_NO_DRIVE_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !tx_en); // R9
endmodule

// File: tb/sim_rom_cmd_engine.sv
module sim_rom_cmd_engine;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0]  FAM = 8'h08;
  localparam logic [47:0] SER = 48'h00A3_5C71_E904;

  logic clk, rst_n, line_rst, wr_stb, wr_bit, rd_stb;
  logic tx_en, tx_bit, mem_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [63:0] exp_id;

  rom_cmd_engine #(.FAMILY_CODE(FAM), .SERIAL_NO(SER)) u0 (
    .clk(clk), .rst_n(rst_n), .line_rst(line_rst), .wr_stb(wr_stb),
    .wr_bit(wr_bit), .rd_stb(rd_stb), .tx_en(tx_en), .tx_bit(tx_bit),
    .mem_en(mem_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stage-by-stage form of the shift register: bit 7 takes the feedback,
  // stages 3 and 2 are xored with it after the shift
  function automatic logic [7:0] crc_feed(input logic [7:0] r, input logic d);
    logic fb;
    logic [7:0] n;
    fb   = r[0] ^ d;
    n    = {fb, r[7:1]};
    n[3] = n[3] ^ fb;
    n[2] = n[2] ^ fb;
    return n;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    wr_bit = b;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_slot(output logic en, output logic b);
    en = tx_en;
    b  = tx_bit;
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_line_rst();
    line_rst = 1'b1;
    @(negedge clk);
    line_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // command, expected tx_en, expected mem_en right after the 8th bit
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    {8'h33, 1'b1, 1'b0},
    {8'h55, 1'b0, 1'b0},
    {8'hF0, 1'b1, 1'b0},
    {8'hCC, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b0},
    {8'hC3, 1'b0, 1'b0},
    {8'h0F, 1'b0, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] crc;
    logic en, b, en2, c;
    logic [63:0] got;

    rst_n = 1'b0; line_rst = 1'b0; wr_stb = 1'b0; wr_bit = 1'b0; rd_stb = 1'b0;
    crc = '0;
    for (int i = 0; i < 56; i++) crc = crc_feed(crc, (i < 8) ? FAM[i] : SER[i-8]);
    exp_id = {crc, SER, FAM};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10", "tx_en after reset", tx_en, 0);
    check("R10", "mem_en after reset", mem_en, 0);

    // R3 residue over the full identity
    crc = '0;
    for (int i = 0; i < 64; i++) crc = crc_feed(crc, exp_id[i]);
    check("R3", "residue of identity", crc, 0);

    // R1 R6 R7 command table walk
    for (int v = 0; v < NV; v++) begin
      pulse_line_rst();
      send_byte(VEC[v][9:2]);
      check("R1/R6/R7", $sformatf("tx_en after cmd %02h", VEC[v][9:2]), tx_en, VEC[v][1]);
      check("R1/R6/R7", $sformatf("mem_en after cmd %02h", VEC[v][9:2]), mem_en, VEC[v][0]);
    end

    // R1 read strobes ignored during command collection
    pulse_line_rst();
    send_bit(1'b0);
    read_slot(en, b);
    check("R1", "no drive during command", en, 0);
    for (int i = 1; i < 8; i++) send_bit(OP_SKIP_BIT(i));
    check("R1", "skip still decoded", mem_en, 1);

    // R2 full read, R3 check byte on the wire
    pulse_line_rst();
    send_byte(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      read_slot(en, b);
      got[i] = b;
      if (!en) check("R2", $sformatf("tx_en bit %0d", i), en, 1);
    end
    check("R2", "identity read out", got, exp_id);
    check("R3", "check byte read out", got[63:56], exp_id[63:56]);
    check("R2", "grant after read", mem_en, 1);
    check("R9", "no drive in grant", tx_en, 0);

    // R4 matching identity
    pulse_line_rst();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit(exp_id[i]);
    check("R4", "grant after match", mem_en, 1);

    // R4 mismatch at bit 40, later bits ignored
    pulse_line_rst();
    send_byte(8'h55);
    for (int i = 0; i < 64; i++) send_bit((i == 40) ? ~exp_id[i] : exp_id[i]);
    check("R4", "no grant after mismatch", mem_en, 0);
    read_slot(en, b);
    check("R9", "silent after mismatch", en, 0);

    // R5 full search
    pulse_line_rst();
    send_byte(8'hF0);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      read_slot(en, b);
      read_slot(en2, c);
      got[i] = b;
      if (!(en && en2 && c == ~b)) check("R5", $sformatf("bit/complement %0d", i), {en, en2, c}, {2'b11, ~b});
      send_bit(exp_id[i]);
    end
    check("R5", "search bits", got, exp_id);
    check("R5", "grant after search", mem_en, 1);

    // R5 wrong direction at bit 10
    pulse_line_rst();
    send_byte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      read_slot(en, b);
      read_slot(en2, c);
      send_bit((i == 10) ? ~exp_id[i] : exp_id[i]);
    end
    read_slot(en, b);
    check("R5", "dropped out of search", en, 0);
    check("R5", "no grant after drop", mem_en, 0);

    // R8 line reset clears grant and restarts command collection
    pulse_line_rst();
    send_byte(8'hCC);
    line_rst = 1'b1;
    @(negedge clk);
    line_rst = 1'b0;
    check("R8", "grant cleared by line reset", mem_en, 0);
    @(negedge clk);
    send_byte(8'h33);
    read_slot(en, b);
    read_slot(en, b);
    pulse_line_rst();
    check("R8", "no drive after mid-read reset", tx_en, 0);
    send_byte(8'hCC);
    check("R8", "command accepted after mid-read reset", mem_en, 1);

    // R10 asynchronous reset from grant
    rst_n = 1'b0;
    #1;
    check("R10", "async reset clears grant", mem_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    send_byte(8'hCC);
    check("R10", "waits for command after reset", mem_en, 1);

    finish_up();
  end

  function automatic logic OP_SKIP_BIT(input int i);
    logic [7:0] k;
    k = 8'hCC;
    return k[i];
  endfunction
endmodule